// File: doc/BRIEF.md
# Fixed-Point Rounding Right Shifter

This unit takes a wide pre-rounding value, discards a chosen number of its least-significant bits, and adds a one-bit rounding increment whose rule is picked by a 2-bit mode. It is the scale-down-and-round step that sits behind fixed-point scaling and narrowing operations. Saturation to a narrower destination, element packing and the origin of the mode setting are handled elsewhere.

The shift amount `d` runs from 0 to W-1. The result is `(v >> d) + r`, returned on W bits with a separate carry bit that holds bit W of that sum. When `PIPE` is 1, one register stage sits on the output and a valid flag follows the input valid one clock later. When `PIPE` is 0, the unit is purely combinational and the valid flag passes straight through.

Top module: `fxround_shifter`

## Requirements
- R1: With a shift of 0, the increment is 0 in every mode and the result equals the input value.
- R2: Mode 2'b00 (nearest, ties up) adds the most significant discarded bit, v[d-1].
- R3: Mode 2'b01 (nearest, ties to even) adds 1 only when v[d-1] is set and either some bit below it, v[d-2:0], is set or the kept LSB v[d] is set. When d = 1 the range below the guard bit is empty and counts as zero.
- R4: Mode 2'b10 (truncate) adds nothing, so the result is v >> d.
- R5: Mode 2'b11 (round to odd) adds 1 only when the kept LSB v[d] is clear and at least one discarded bit v[d-1:0] is set. As a result, the result LSB is 1 whenever any discarded bit is set.
- R6: `resCarry` carries bit W of the (W+1)-bit sum. For every legal shift it is 0.
- R7: With PIPE = 1, a value presented with `inValid` high appears on `resValue`/`resCarry` after the next rising clock edge, and `resValid` equals `inValid` delayed by one clock. Values presented on back-to-back cycles come out on back-to-back cycles.
- R8: With PIPE = 1, `resValue` and `resCarry` hold their last result while `inValid` is low, whatever the other inputs do.
- R9: While `rstN` is low, `resValid`, `resValue` and `resCarry` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input operands are valid this cycle |
| inValue | input | W | Pre-rounding value v |
| inShift | input | $clog2(W) | Number of low bits to discard, d |
| inMode | input | 2 | Rounding mode: 00 ties-up, 01 ties-even, 10 truncate, 11 round-to-odd |
| resValid | output | 1 | Result is valid |
| resValue | output | W | Shifted and rounded result |
| resCarry | output | 1 | Bit W of the rounded sum |

## Verification
The bench targets four areas:

- **Zero shift.** The d = 0 case catches a design that reads a guard bit from v[-1] or from a wrapped index, which would make the output differ from the input.
- **Ties to even at d = 1.** A design that forgets the empty range below the guard bit would see a spurious sticky bit and round 0.5 up to odd instead of to even.
- **Ties at larger shifts.** Exact ties with kept LSBs of 0 and 1 separate ties-even from ties-up.
- **Round to odd and the top shift.** Inputs with a set kept LSB show whether a jam design wrongly adds on top of an already odd result. The top shift amount d = W-1 exposes off-by-one mask errors.

Hold and back-to-back cases show whether the output register loads only on valid input.

// File: rtl/fxr_pkg.sv
`timescale 1ns/1ps
package fxr_pkg;

  typedef enum logic [1:0] {
    RND_NEAR_UP   = 2'b00,
    RND_NEAR_EVEN = 2'b01,
    RND_DOWN      = 2'b10,
    RND_ODD       = 2'b11
  } rnd_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic useGuard;     // add guard bit directly
    logic useEven;      // guard qualified by sticky or kept LSB
    logic useOdd;       // jam into kept LSB
    logic shiftNonZero; // at least one bit discarded
    logic capture;      // load output register
  } rnd_ctl_t;

endpackage

// File: rtl/fxr_ctrl.sv
`timescale 1ns/1ps
module fxr_ctrl
  import fxr_pkg::*;
#(
  parameter int SW   = 4,
  parameter bit PIPE = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [SW-1:0] inShift,
  input  logic [1:0]    inMode,
  output rnd_ctl_t      ctl,
  output logic          resValid
);

  rnd_mode_e modeSel;

  always_comb begin
    modeSel          = rnd_mode_e'(inMode);
    ctl              = '0;
    ctl.shiftNonZero = |inShift;
    ctl.capture      = inValid;
    unique case (modeSel)
      RND_NEAR_UP:   ctl.useGuard = 1'b1;
      RND_NEAR_EVEN: ctl.useEven  = 1'b1;
      RND_ODD:       ctl.useOdd   = 1'b1;
      default:       ;
    endcase
  end

  generate
    if (PIPE) begin : g_validReg
      logic validQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) validQ <= 1'b0;
        else       validQ <= inValid;
      end
      assign resValid = validQ;

      assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> resValid);
      assert_valid_drops_R7: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> !resValid);
    end else begin : g_validPass
      assign resValid = inValid;
    end
  endgenerate

  assert_single_rule_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.useGuard, ctl.useEven, ctl.useOdd}));

endmodule

// File: rtl/fxr_datapath.sv
`timescale 1ns/1ps
module fxr_datapath
  import fxr_pkg::*;
#(
  parameter int W    = 16,
  parameter int SW   = 4,
  parameter bit PIPE = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [W-1:0]  inValue,
  input  logic [SW-1:0] inShift,
  input  rnd_ctl_t      ctl,
  output logic [W-1:0]  resValue,
  output logic          resCarry
);

  logic [SW-1:0] shMinusOne;
  logic [W-1:0]  shifted;
  logic [W-1:0]  guardAligned;
  logic [W-1:0]  belowGuardMask;
  logic          guardBit;
  logic          stickyBit;
  logic          lsbBit;
  logic          anyDropped;
  logic          roundInc;
  logic [W:0]    roundSum;

  always_comb begin
    shMinusOne     = inShift - SW'(1);
    shifted        = inValue >> inShift;
    guardAligned   = inValue >> shMinusOne;
    belowGuardMask = (W'(1) << shMinusOne) - W'(1);
    guardBit       = ctl.shiftNonZero & guardAligned[0];
    stickyBit      = ctl.shiftNonZero & (|(inValue & belowGuardMask));
    lsbBit         = shifted[0];
    anyDropped     = guardBit | stickyBit;
    roundInc       = (ctl.useGuard & guardBit)
                   | (ctl.useEven  & guardBit & (stickyBit | lsbBit))
                   | (ctl.useOdd   & ~lsbBit & anyDropped);
    roundSum       = {1'b0, shifted} + (W+1)'(roundInc);
  end

  generate
    if (PIPE) begin : g_outReg
      logic [W-1:0] valueQ;
      logic         carryQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          valueQ <= '0;
          carryQ <= 1'b0;
        end else if (ctl.capture) begin
          valueQ <= roundSum[W-1:0];
          carryQ <= roundSum[W];
        end
      end
      assign resValue = valueQ;
      assign resCarry = carryQ;

      assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
        !ctl.capture |=> ($stable(resValue) && $stable(resCarry)));
      assert_load_value_R7: assert property (@(posedge clk) disable iff (!rstN)
        ctl.capture |=> (resValue == $past(roundSum[W-1:0])));
    end else begin : g_outPass
      assign resValue = roundSum[W-1:0];
      assign resCarry = roundSum[W];
    end
  endgenerate

  assert_zero_shift_pass_R1: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.shiftNonZero |-> (roundSum == {1'b0, inValue}));
  assert_trunc_exact_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.useGuard || ctl.useEven || ctl.useOdd) |-> (roundSum[W-1:0] == shifted));
  assert_even_tie_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.useEven && guardBit && !stickyBit) |-> !roundSum[0]);
  assert_odd_jam_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.useOdd && anyDropped) |-> roundSum[0]);
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shiftNonZero |-> !roundSum[W]);

endmodule

// File: rtl/fxround_shifter.sv
`timescale 1ns/1ps
module fxround_shifter
  import fxr_pkg::*;
#(
  parameter int W    = 16,
  parameter bit PIPE = 1'b1,
  localparam int SW  = $clog2(W)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [W-1:0]  inValue,
  input  logic [SW-1:0] inShift,
  input  logic [1:0]    inMode,
  output logic          resValid,
  output logic [W-1:0]  resValue,
  output logic          resCarry
);

  rnd_ctl_t ctl;

  fxr_ctrl #(.SW(SW), .PIPE(PIPE)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inShift  (inShift),
    .inMode   (inMode),
    .ctl      (ctl),
    .resValid (resValid)
  );

  fxr_datapath #(.W(W), .SW(SW), .PIPE(PIPE)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .inValue  (inValue),
    .inShift  (inShift),
    .ctl      (ctl),
    .resValue (resValue),
    .resCarry (resCarry)
  );

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rstN |-> (!resValid && resValue == '0 && !resCarry));

endmodule

// File: tb/fxround_shifter_bench.sv
`timescale 1ns/1ps
module fxround_shifter_bench;

  localparam int W  = 16;
  localparam int SW = 4;
  localparam int NV = 24;

  // {value, shift, mode, expected}
  localparam logic [37:0] VEC [NV] = '{
    {16'h00B7, 4'd0,  2'd0, 16'h00B7},
    {16'h00B7, 4'd0,  2'd1, 16'h00B7},
    {16'h00B7, 4'd0,  2'd3, 16'h00B7},
    {16'h0006, 4'd2,  2'd0, 16'h0002},
    {16'h0006, 4'd2,  2'd1, 16'h0002},
    {16'h0002, 4'd2,  2'd1, 16'h0000},
    {16'h0002, 4'd2,  2'd0, 16'h0001},
    {16'h0003, 4'd1,  2'd1, 16'h0002},
    {16'h0001, 4'd1,  2'd1, 16'h0000},
    {16'h0001, 4'd1,  2'd0, 16'h0001},
    {16'h00FF, 4'd4,  2'd2, 16'h000F},
    {16'h0010, 4'd4,  2'd3, 16'h0001},
    {16'h0021, 4'd4,  2'd3, 16'h0003},
    {16'h0031, 4'd4,  2'd3, 16'h0003},
    {16'hFFFF, 4'd15, 2'd0, 16'h0002},
    {16'hFFFF, 4'd15, 2'd1, 16'h0002},
    {16'hFFFF, 4'd15, 2'd2, 16'h0001},
    {16'hFFFF, 4'd15, 2'd3, 16'h0001},
    {16'h8000, 4'd15, 2'd1, 16'h0001},
    {16'h4000, 4'd15, 2'd1, 16'h0000},
    {16'h4000, 4'd15, 2'd0, 16'h0001},
    {16'h0058, 4'd4,  2'd1, 16'h0006},
    {16'h0058, 4'd4,  2'd3, 16'h0005},
    {16'h0007, 4'd1,  2'd3, 16'h0003}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [W-1:0]  inValue = '0;
  logic [SW-1:0] inShift = '0;
  logic [1:0]    inMode = '0;
  logic          resValid;
  logic [W-1:0]  resValue;
  logic          resCarry;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fxround_shifter #(.W(W), .PIPE(1'b1)) u_fxround_shifter (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inValue(inValue),
    .inShift(inShift), .inMode(inMode), .resValid(resValid),
    .resValue(resValue), .resCarry(resCarry)
  );

  task automatic check(input string req, input logic [W+1:0] act, input logic [W+1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference from the rounding rules: returns {carry, value}
  function automatic logic [W:0] refRound(logic [W-1:0] v, int d, int m);
    logic [W-1:0] kept;
    logic g, s, l, r;
    kept = v >> d;
    g = (d > 0) ? v[d-1] : 1'b0;
    s = 1'b0;
    for (int i = 0; i < d - 1; i++) s = s | v[i];
    l = kept[0];
    case (m)
      0: r = g;
      1: r = g & (s | l);
      2: r = 1'b0;
      default: r = ~l & (g | s);
    endcase
    return {1'b0, kept} + (W+1)'(r);
  endfunction

  function automatic string reqFor(int d, int m);
    if (d == 0) return "R1";
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  // drive one operand, check one cycle later
  task automatic runOne(input logic [W-1:0] v, input int d, input int m,
                        input logic [W:0] exp, input string req);
    @(negedge clk);
    inValid = 1'b1; inValue = v; inShift = SW'(d); inMode = 2'(m);
    @(negedge clk);
    inValid = 1'b0;
    check(req, {resValid, resCarry, resValue}, {1'b1, exp});
    check("R6", {1'b0, 1'b0, resCarry, 15'd0}, '0);
  endtask

  initial begin
    #3;
    check("R9", {resValid, resCarry, resValue}, '0);
    repeat (2) @(negedge clk);
    check("R9", {resValid, resCarry, resValue}, '0);
    rstN = 1'b1;

    for (int k = 0; k < NV; k++) begin
      runOne(VEC[k][37:22], int'(VEC[k][21:18]), int'(VEC[k][17:16]),
             {1'b0, VEC[k][15:0]}, reqFor(int'(VEC[k][21:18]), int'(VEC[k][17:16])));
    end

    // sweep against rule-based reference
    for (int d = 0; d < W; d++) begin
      for (int m = 0; m < 4; m++) begin
        runOne(16'h5A5A, d, m, refRound(16'h5A5A, d, m), reqFor(d, m));
        runOne(16'h8001, d, m, refRound(16'h8001, d, m), reqFor(d, m));
        runOne(16'h1238, d, m, refRound(16'h1238, d, m), reqFor(d, m));
      end
    end

    // R8: hold while idle, even with other operands on the inputs
    runOne(16'h0058, 4, 1, 17'h00006, "R3");
    @(negedge clk);
    inValid = 1'b0; inValue = 16'hFFFF; inShift = 4'd1; inMode = 2'd0;
    @(negedge clk);
    check("R8", {resValid, resCarry, resValue}, {2'b00, 16'h0006});
    @(negedge clk);
    check("R8", {resValid, resCarry, resValue}, {2'b00, 16'h0006});

    // R7: back-to-back operands
    @(negedge clk);
    inValid = 1'b1; inValue = 16'h0003; inShift = 4'd1; inMode = 2'd1;
    @(negedge clk);
    check("R7", {resValid, resCarry, resValue}, {2'b10, 16'h0002});
    inValue = 16'h00FF; inShift = 4'd4; inMode = 2'd2;
    @(negedge clk);
    check("R7", {resValid, resCarry, resValue}, {2'b10, 16'h000F});
    inValid = 1'b0;
    @(negedge clk);
    check("R7", {resValid, 17'd0}, '0);

    // R9: reset mid-run clears the output
    rstN = 1'b0;
    #1;
    check("R9", {resValid, resCarry, resValue}, '0);
    @(negedge clk);
    rstN = 1'b1;

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule